// File: doc/BRIEF.md
# MFM Write Encoder

This block converts a stream of bytes into the serial cell pattern written to a floppy disk at double density. Every data bit is preceded by a clock cell, so a byte becomes sixteen cells, each lasting one cell period of `CELL_DIV` system clocks. The defaults are 250 clocks at 125 MHz, which gives 2 µs per cell and a 250 kbit/s data rate. A clock cell is written as 1 only when the data bits on both sides of it are 0. The data bit on the earlier side of the first clock cell of a byte is the last bit of the previous byte, so the block keeps that bit from one byte to the next. Each cell of value 1 becomes one short active-low pulse on the write-data line.

A producer offers bytes on a valid/ready port while the write gate is high. The block holds one byte ahead of the byte it is shifting out. When a byte ends and no byte is waiting, the block sends a zero byte and raises a sticky underrun flag. A byte offered together with the mark request is sent as the address-mark pattern, in which one clock cell is deliberately left out. Dropping the write gate clears all state.

Top module: `mfm_wr_encoder`

## Requirements
- R1: A byte is sent as sixteen cells, one every `CELL_DIV` clocks. The cells come in pairs, a clock cell then a data cell, starting with data bit 7. In this text a cell word is a 16-bit value whose most significant bit is the first cell sent. The pulse of cell n of a write starts (n+1)·`CELL_DIV`+2 clocks after the first clock edge that samples `wr_gate` high.
- R2: A clock cell is 1 exactly when the data bits before and after it are both 0.
- R3: A data cell equals its data bit. For example, 0xFF sent after a 0 bit gives the cell word 0x5555.
- R4: The clock cell ahead of bit 7 uses bit 0 of the previous byte. For the first byte after `wr_gate` rises, that previous bit is taken as 0. So 0x00 gives 0xAAAA as the first byte of a write and 0x2AAA when it follows a byte ending in 1.
- R5: `in_ready` is high only when all three of these hold: `wr_gate` was high on the previous edge, no byte is waiting, and every cell of the current byte has been sent. After a byte is accepted, `in_ready` stays low until that byte's sixteenth cell has been sent.
- R6: Each cell of value 1 drives `wr_pulse_n` low for exactly `PULSE_W` clocks. The line is high at all other times. `PULSE_W` must be less than `CELL_DIV`.
- R7: After an edge that samples `wr_gate` low, no new pulse starts and `in_ready` is low. A pulse that is already running finishes at its full width.
- R8: When a byte ends and no byte is waiting or being accepted, a zero byte is sent and `underrun` goes to 1. It stays at 1 until `wr_gate` is dropped. A byte that is accepted by the time the current byte ends never causes an underrun.
- R9: A byte accepted with `in_mark` high is sent as 0xA1 whatever `in_data` holds. In that byte, the clock cell ahead of data bit 2 is forced to 0, giving the cell word 0x4489. The next byte sees bit 0 as 1. An ordinary 0xA1 sent after a 0 bit gives 0x44A9.
- R10: While `rst` is high, `wr_pulse_n` is 1, `in_ready` is 0 and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_gate | input | 1 | Write enable; low clears the encoder |
| in_data | input | 8 | Byte to encode |
| in_mark | input | 1 | Send the missing-clock mark instead of `in_data` |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken on this edge |
| wr_pulse_n | output | 1 | Active-low write pulse, one per 1 cell |
| underrun | output | 1 | Sticky: a zero byte was sent for lack of data |

## Verification
The byte sequence 0x00, 0xFF, 0x01, 0x80, 0x5A covers several cases. It has clock cells that are all set, data cells that are all set, and a 1 bit at the end of one byte followed by a 1 bit at the start of the next, which shows whether the carried bit is used. A single byte followed by starvation shows whether the zero fill follows the carried bit (0x2AAA, then 0xAAAA). A mark followed by 0x00 and an ordinary 0xA1 shows whether the clock cell is dropped only when the mark is requested. A gate pause between two writes shows whether the carried bit is cleared and whether pulses stop.

// File: rtl/mfm_enc_pkg.sv
package mfm_enc_pkg;
  localparam int DATA_W = 8;
  localparam int CELLS  = 2 * DATA_W;
  localparam int LEFT_W = $clog2(CELLS);
  // data byte of the address mark and the cell-word bit whose clock is dropped
  localparam logic [DATA_W-1:0] MARK_DATA = 8'hA1;
  localparam int MARK_MISS = 5;

  typedef logic [CELLS-1:0] cell_word_t;

  typedef struct packed {
    logic              mark;
    logic [DATA_W-1:0] data;
  } wr_item_t;
endpackage

// File: rtl/mfm_cell_timer.sv
module mfm_cell_timer #(
  parameter int CELL_DIV = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (CELL_DIV > 2) ? $clog2(CELL_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/mfm_cell_word.sv
module mfm_cell_word
  import mfm_enc_pkg::*;
(
  input  wr_item_t   item,
  input  logic       prev_bit,
  output cell_word_t word
);
  logic [DATA_W-1:0] d;
  assign d = item.mark ? MARK_DATA : item.data;

  for (genvar g = 0; g < DATA_W; g++) begin : g_pair
    logic nb;
    if (g == DATA_W - 1) begin : g_first
      assign nb = prev_bit;
    end else begin : g_inner
      assign nb = d[g+1];
    end
    assign word[2*g] = d[g];
    if (2*g + 1 == MARK_MISS) begin : g_miss
      assign word[2*g+1] = ~(nb | d[g]) & ~item.mark;
    end else begin : g_clk
      assign word[2*g+1] = ~(nb | d[g]);
    end
  end
endmodule

// File: rtl/mfm_shift_ctl.sv
module mfm_shift_ctl
  import mfm_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     tick,
  input  wr_item_t in_item,
  input  logic     in_valid,
  output logic     in_ready,
  output logic     cell_stb,
  output logic     cell_bit,
  output logic     underrun
);
  wr_item_t          hold_q;
  logic              hold_full_q;
  logic [CELLS-2:0]  sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              prev_q;
  logic              stb_q;
  logic              bit_q;
  logic              unr_q;

  logic       accept;
  logic       boundary;
  logic       have;
  wr_item_t   cur;
  cell_word_t word;

  assign in_ready = run && !hold_full_q && (left_q == '0);
  assign accept   = in_valid && in_ready;
  assign boundary = tick && (left_q == '0);
  assign have     = hold_full_q || accept;

  always_comb begin
    cur = '0;
    if (hold_full_q)  cur = hold_q;
    else if (accept)  cur = in_item;
  end

  mfm_cell_word u_word (
    .item     (cur),
    .prev_bit (prev_q),
    .word     (word)
  );

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      sh_q        <= '0;
      left_q      <= '0;
      prev_q      <= 1'b0;
      stb_q       <= 1'b0;
      bit_q       <= 1'b0;
      unr_q       <= 1'b0;
    end else begin
      stb_q <= tick;
      if (boundary) begin
        bit_q       <= word[CELLS-1];
        sh_q        <= word[CELLS-2:0];
        left_q      <= LEFT_W'(CELLS - 1);
        prev_q      <= word[0];
        hold_full_q <= 1'b0;
        if (!have) unr_q <= 1'b1;
      end else begin
        if (accept) begin
          hold_q      <= in_item;
          hold_full_q <= 1'b1;
        end
        if (tick) begin
          bit_q  <= sh_q[CELLS-2];
          sh_q   <= {sh_q[CELLS-3:0], 1'b0};
          left_q <= left_q - LEFT_W'(1);
        end
      end
    end
  end

  assign cell_stb = stb_q;
  assign cell_bit = bit_q;
  assign underrun = unr_q;
endmodule

// File: rtl/mfm_pulse_shaper.sv
module mfm_pulse_shaper #(
  parameter int PULSE_W = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic cell_stb,
  input  logic cell_bit,
  output logic pulse_n
);
  localparam int CNT_W = $clog2(PULSE_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pulse_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      pulse_n_q <= 1'b1;
    end else if (run && cell_stb && cell_bit) begin
      cnt_q     <= CNT_W'(PULSE_W - 1);
      pulse_n_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else begin
      pulse_n_q <= 1'b1;
    end
  end

  assign pulse_n = pulse_n_q;
endmodule

// File: rtl/mfm_wr_encoder.sv
module mfm_wr_encoder
  import mfm_enc_pkg::*;
#(
  parameter int CELL_DIV = 250,
  parameter int PULSE_W  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_gate,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_pulse_n,
  output logic              underrun
);
  logic     gate_q;
  logic     tick;
  logic     cell_stb;
  logic     cell_bit;
  wr_item_t item;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= wr_gate;
  end

  assign item.mark = in_mark;
  assign item.data = in_data;

  mfm_cell_timer #(.CELL_DIV(CELL_DIV)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (gate_q),
    .tick (tick)
  );

  mfm_shift_ctl u_shift (
    .clk      (clk),
    .rst      (rst),
    .run      (gate_q),
    .tick     (tick),
    .in_item  (item),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .cell_stb (cell_stb),
    .cell_bit (cell_bit),
    .underrun (underrun)
  );

  mfm_pulse_shaper #(.PULSE_W(PULSE_W)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .run      (gate_q),
    .cell_stb (cell_stb),
    .cell_bit (cell_bit),
    .pulse_n  (wr_pulse_n)
  );
endmodule

// File: rtl/mfm_wr_encoder_chk.sv
module mfm_wr_encoder_chk #(
  parameter int CELL_DIV = 250,
  parameter int PULSE_W  = 31
) (
  input logic clk,
  input logic rst,
  input logic wr_gate,
  input logic in_valid,
  input logic in_ready,
  input logic wr_pulse_n,
  input logic underrun
);
  logic        pn_q;
  logic        fell_now;
  logic        rose_now;
  logic        have_prev_q;
  logic [15:0] gap_q;
  logic [15:0] lowrun_q;

  assign fell_now = pn_q && !wr_pulse_n;
  assign rose_now = !pn_q && wr_pulse_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pn_q        <= 1'b1;
      have_prev_q <= 1'b0;
      gap_q       <= '0;
      lowrun_q    <= '0;
    end else begin
      pn_q     <= wr_pulse_n;
      lowrun_q <= wr_pulse_n ? 16'd0 : lowrun_q + 16'd1;
      if (fell_now)           gap_q <= 16'd1;
      else if (gap_q != '1)   gap_q <= gap_q + 16'd1;
      if (!wr_gate)           have_prev_q <= 1'b0;
      else if (fell_now)      have_prev_q <= 1'b1;
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    rose_now |-> (lowrun_q == 16'(PULSE_W))); // R6

  AST_FLUX_GAP: assert property (@(posedge clk) disable iff (rst)
    (fell_now && have_prev_q && wr_gate) |->
      (gap_q >= 16'(2*CELL_DIV) && gap_q <= 16'(4*CELL_DIV) && (gap_q % 16'(CELL_DIV)) == 16'd0)); // R2

  AST_GATE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wr_gate && !$past(wr_gate) && wr_pulse_n) |=> wr_pulse_n); // R7

  AST_READY_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> $past(wr_gate)); // R5

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R5

  AST_UNDERRUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (underrun && wr_gate && $past(wr_gate)) |=> underrun); // R8
endmodule

bind mfm_wr_encoder mfm_wr_encoder_chk #(
  .CELL_DIV (CELL_DIV),
  .PULSE_W  (PULSE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_gate    (wr_gate),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .wr_pulse_n (wr_pulse_n),
  .underrun   (underrun)
);

// File: tb/test_mfm_wr_encoder.sv
module test_mfm_wr_encoder;
  localparam int DIV = 10;
  localparam int PW  = 3;
  localparam int NGOT = 512;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_gate;
  logic [7:0] in_data;
  logic       in_mark;
  logic       in_valid;
  logic       in_ready;
  logic       wr_pulse_n;
  logic       underrun;

  always #4 clk = ~clk;

  mfm_wr_encoder #(.CELL_DIV(DIV), .PULSE_W(PW)) i_mfm_wr_encoder (
    .clk        (clk),
    .rst        (rst),
    .wr_gate    (wr_gate),
    .in_data    (in_data),
    .in_mark    (in_mark),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .wr_pulse_n (wr_pulse_n),
    .underrun   (underrun)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int start_cyc = 0;
  int align_bad = 0;
  int width_bad = 0;
  int n_falls = 0;
  int lowcnt = 0;
  logic prev_pn = 1'b1;
  logic got [NGOT];

  always @(posedge clk) cyc <= cyc + 1;

  // cell recorder: a falling edge marks a 1 cell; its index follows from R1 timing
  always @(negedge clk) begin
    int rel;
    if (prev_pn === 1'b1 && wr_pulse_n === 1'b0) begin
      n_falls++;
      rel = cyc - start_cyc - 2;
      if (rel < DIV || (rel % DIV) != 0) align_bad++;
      else if (rel / DIV - 1 < NGOT) got[rel / DIV - 1] = 1'b1;
    end
    if (wr_pulse_n === 1'b0) lowcnt++;
    else begin
      if (prev_pn === 1'b0 && lowcnt != PW) width_bad++;
      lowcnt = 0;
    end
    prev_pn = wr_pulse_n;
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mfm_ref(input logic [7:0] d, input logic p, input logic m);
    logic [15:0] w;
    logic left;
    if (m) return 16'h4489;
    left = p;
    for (int i = 7; i >= 0; i--) begin
      w[2*i+1] = ~(left | d[i]);
      w[2*i]   = d[i];
      left     = d[i];
    end
    return w;
  endfunction

  function automatic logic [15:0] word_at(input int b);
    logic [15:0] w;
    for (int j = 0; j < 16; j++) w[15-j] = got[16*b + j];
    return w;
  endfunction

  task automatic gate_on();
    for (int i = 0; i < NGOT; i++) got[i] = 1'b0;
    align_bad = 0;
    width_bad = 0;
    wr_gate   = 1'b1;
    start_cyc = cyc;
  endtask

  task automatic gate_off();
    wr_gate = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic m);
    in_data  = d;
    in_mark  = m;
    in_valid = 1'b1;
    while (in_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_mark  = 1'b0;
  endtask

  task automatic wait_cells(input int n);
    while (cyc < start_cyc + (n + 1) * DIV + 2 + PW + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R10", "pulse line in reset", 32'(wr_pulse_n), 32'd1);
    chk("R10", "ready in reset", 32'(in_ready), 32'd0);
    chk("R10", "underrun in reset", 32'(underrun), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "ready with gate low", 32'(in_ready), 32'd0);
  endtask

  task automatic t_stream();
    logic [7:0] seq [5];
    logic p;
    seq = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A};
    gate_on();
    send(seq[0], 1'b0);
    chk("R5", "ready while a byte waits", 32'(in_ready), 32'd0);
    for (int i = 1; i < 5; i++) send(seq[i], 1'b0);
    chk("R8", "no underrun with steady supply", 32'(underrun), 32'd0);
    repeat (3 * DIV) @(negedge clk);
    chk("R5", "ready while shifting", 32'(in_ready), 32'd0);
    wait_cells(80);
    p = 1'b0;
    for (int b = 0; b < 5; b++) begin
      chk("R1/R2/R3", $sformatf("cell word of byte %0d", b), 32'(word_at(b)), 32'(mfm_ref(seq[b], p, 1'b0)));
      p = seq[b][0];
    end
    chk("R4", "first byte 0x00 after gate", 32'(word_at(0)), 32'h0000AAAA);
    chk("R3", "0xFF after 0 bit", 32'(word_at(1)), 32'h00005555);
    chk("R4", "0x01 after byte ending in 1", 32'(word_at(2)), 32'h00002AA9);
    chk("R1", "pulse alignment errors", 32'(align_bad), 32'd0);
    chk("R6", "pulse width errors", 32'(width_bad), 32'd0);
    gate_off();
  endtask

  task automatic t_underrun();
    gate_on();
    send(8'h01, 1'b0);
    chk("R8", "no underrun before first boundary", 32'(underrun), 32'd0);
    wait_cells(48);
    chk("R8", "underrun raised", 32'(underrun), 32'd1);
    chk("R1", "byte 0x01", 32'(word_at(0)), 32'(mfm_ref(8'h01, 1'b0, 1'b0)));
    chk("R8", "zero fill after bit 1", 32'(word_at(1)), 32'h00002AAA);
    chk("R8", "zero fill after bit 0", 32'(word_at(2)), 32'h0000AAAA);
    chk("R6", "pulse width errors", 32'(width_bad), 32'd0);
    gate_off();
    chk("R8", "underrun cleared by gate", 32'(underrun), 32'd0);
    chk("R7", "ready with gate low", 32'(in_ready), 32'd0);
  endtask

  task automatic t_mark();
    gate_on();
    send(8'h5A, 1'b1);
    send(8'h00, 1'b0);
    send(8'hA1, 1'b0);
    wait_cells(48);
    chk("R9", "mark pattern", 32'(word_at(0)), 32'h00004489);
    chk("R9", "carry after mark", 32'(word_at(1)), 32'h00002AAA);
    chk("R9", "plain 0xA1 keeps clock", 32'(word_at(2)), 32'h000044A9);
    chk("R1", "pulse alignment errors", 32'(align_bad), 32'd0);
    gate_off();
  endtask

  task automatic t_gate();
    int base;
    gate_on();
    send(8'h01, 1'b0);
    wait_cells(16);
    wr_gate = 1'b0;
    base = n_falls;
    repeat (6 * DIV) @(negedge clk);
    chk("R7", "no pulses with gate low", 32'(n_falls), 32'(base));
    chk("R7", "line idle with gate low", 32'(wr_pulse_n), 32'd1);
    chk("R7", "ready low with gate low", 32'(in_ready), 32'd0);
    gate_on();
    send(8'h00, 1'b0);
    wait_cells(16);
    chk("R4", "carried bit cleared on new gate", 32'(word_at(0)), 32'h0000AAAA);
    gate_off();
  endtask

  task automatic run_all();
    t_reset();
    t_stream();
    t_underrun();
    t_mark();
    t_gate();
  endtask

  initial begin
    rst      = 1'b1;
    wr_gate  = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    in_mark  = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule